// File: doc/BRIEF.md
# Column Driver Load Sequencer

This block drives a serial-in, latched, 32-column panel driver from a fast system clock. It takes one 32-bit line word through a valid/ready handshake and splits it into two interleaved streams. Bits for odd column positions go out on one serial line and bits for even positions on the other. It produces 16 shift-clock pulses, then a latch-enable pulse, and then one display phase in which strobe is low and sustain is high. The outputs stay blank (sustain low) for the whole load.

Every pulse width, setup and hold figure is a parameter given in nanoseconds. The block turns each one into system-clock cycles, rounding up. The display phase length comes from an input sampled when the word is accepted, and it never drops below the minimum strobe/sustain pulse width. Word bit j (0-based) is column position j+1.

Top module: `panel_load_seq`

## Requirements
- R1: After reset, wordReady is 1, shiftClk, latchEn and sustain are 0, and strobe is 1.
- R2: wordReady is 1 only while the block is idle. A word is taken on a clock edge where wordValid and wordReady are both 1. While shiftClk, latchEn or sustain is high, wordReady is 0.
- R3: Exactly 16 falling shiftClk edges follow each accepted word. At the k-th fall (k = 0..15), sdOdd holds word bit 30-2k and sdEven holds word bit 31-2k, so positions 31 and 32 go out first.
- R4: Each shiftClk high phase lasts exactly 5 cycles (100 ns at the default clock), and each low phase between two pulses also lasts 5 cycles.
- R5: The serial data lines never change while shiftClk is high. They stay unchanged for at least 3 cycles (hold) after each shiftClk fall.
- R6: latchEn rises exactly 3 cycles after the last shiftClk fall, and shiftClk stays low the whole time latchEn is high.
- R7: latchEn is high for exactly 5 cycles (at least 90 ns) per word.
- R8: sustain stays low and strobe stays high while shiftClk or latchEn is high. Sustain rises and strobe falls in the cycle just after latchEn falls.
- R9: sustain stays high, and strobe stays low, for max(dispLen, 100) cycles. 100 cycles is the 2 us minimum pulse.
- R10: After sustain falls, strobe stays high and wordReady stays low for 99 cycles. wordReady then rises, so at least 100 cycles pass before a new word can start.
- R11: A word offered while the display phase runs is not taken and does not disturb the serial lines. It is accepted only once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | A line word is offered |
| wordReady | output | 1 | Block idle, word can be taken |
| wordData | input | WORD_W | Line word, bit j is column j+1 |
| dispLen | input | DISP_W | Requested display length in cycles |
| sdOdd | output | 1 | Serial data for odd column positions |
| sdEven | output | 1 | Serial data for even column positions |
| shiftClk | output | 1 | Shift clock, data taken on its fall |
| latchEn | output | 1 | Latch enable pulse |
| strobe | output | 1 | Strobe, low while latched data is shown |
| sustain | output | 1 | Sustain, high while outputs are driven |

## Verification
Every output is registered. Each phase change therefore appears on the pins one cycle after the control decides it, and all the intervals are measured between pin events rather than from the handshake. A monitor samples the pins on the falling clock edge and counts cycles between events: 5-cycle clock phases, a data change 3 cycles after each fall, latch enable 3 cycles after the last fall, 5 cycles of latch enable, then sustain on the very next cycle for max(dispLen, 100) cycles, and wordReady 99 cycles after sustain drops. Serial data is captured from the sample before each shiftClk fall. Each scenario task compares these counts and captures only after wordReady has returned.

// File: rtl/panel_seq_pkg.sv
`timescale 1ns/1ps
package panel_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SETTLE,
    ST_LATCH,
    ST_DISPLAY,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath, one cycle ahead of the pins
  typedef struct packed {
    logic load;
    logic advance;
    logic clkHigh;
    logic leHigh;
    logic dispOn;
  } seqCtl_t;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int cycFromNs(input int ns, input int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/panel_seq_ctrl.sv
`timescale 1ns/1ps
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int STEPS  = 16,
  parameter int HALF   = 5,
  parameter int HOLD   = 3,
  parameter int GAP    = 3,
  parameter int LEW    = 5,
  parameter int PMIN   = 100,
  parameter int DISP_W = 16,
  parameter int CNT_W  = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic [DISP_W-1:0] dispLen,
  output seqCtl_t           ctl
);

  seqState_t        state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [BIT_W-1:0] bitIdx, bitN;
  logic             hiPhase, hiN;
  logic [CNT_W-1:0] susLimit;
  logic [CNT_W-1:0] reqLen;

  assign reqLen = CNT_W'(dispLen);

  always_comb begin
    stateN    = state;
    cntN      = cnt + 1'b1;
    bitN      = bitIdx;
    hiN       = hiPhase;
    ctl       = '0;
    wordReady = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        cntN = '0;
        if (wordValid) begin
          ctl.load = 1'b1;
          stateN   = ST_SHIFT;
          bitN     = '0;
          hiN      = 1'b0;
        end
      end
      ST_SHIFT: begin
        ctl.clkHigh = hiPhase;
        if (!hiPhase) begin
          if (bitIdx != '0 && cnt == CNT_W'(HOLD)) ctl.advance = 1'b1;
          if (cnt == CNT_W'(HALF - 1)) begin
            hiN  = 1'b1;
            cntN = '0;
          end
        end else if (cnt == CNT_W'(HALF - 1)) begin
          hiN  = 1'b0;
          cntN = '0;
          if (bitIdx == BIT_W'(STEPS - 1)) stateN = ST_SETTLE;
          else                             bitN   = bitIdx + 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt == CNT_W'(GAP - 1)) begin
          stateN = ST_LATCH;
          cntN   = '0;
        end
      end
      ST_LATCH: begin
        ctl.leHigh = 1'b1;
        if (cnt == CNT_W'(LEW - 1)) begin
          stateN = ST_DISPLAY;
          cntN   = '0;
        end
      end
      ST_DISPLAY: begin
        ctl.dispOn = 1'b1;
        if (cnt == susLimit - 1'b1) begin
          stateN = ST_DONE;
          cntN   = '0;
        end
      end
      ST_DONE: begin
        if (cnt == CNT_W'(PMIN - 1)) begin
          stateN = ST_IDLE;
          cntN   = '0;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      hiPhase  <= 1'b0;
      susLimit <= CNT_W'(PMIN);
    end else begin
      state   <= stateN;
      cnt     <= cntN;
      bitIdx  <= bitN;
      hiPhase <= hiN;
      if (ctl.load) susLimit <= (reqLen > CNT_W'(PMIN)) ? reqLen : CNT_W'(PMIN);
    end
  end

endmodule

// File: rtl/panel_seq_data.sv
`timescale 1ns/1ps
module panel_seq_data
  import panel_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STEPS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [WORD_W-1:0] wordData,
  output logic              sdOdd,
  output logic              sdEven,
  output logic              shiftClk,
  output logic              latchEn,
  output logic              strobe,
  output logic              sustain
);

  logic [1:0] laneOut;

  // lane 0 carries odd positions (even bit indices), lane 1 the even positions
  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    logic [STEPS-1:0] laneReg;
    logic [STEPS-1:0] laneInit;

    always_comb begin
      for (int i = 0; i < STEPS; i++) laneInit[i] = wordData[2*i + ln];
    end

    always_ff @(posedge clk) begin
      if (!rstN)            laneReg <= '0;
      else if (ctl.load)    laneReg <= laneInit;
      else if (ctl.advance) laneReg <= {laneReg[STEPS-2:0], 1'b0};
    end

    assign laneOut[ln] = laneReg[STEPS-1];
  end

  assign sdOdd  = laneOut[0];
  assign sdEven = laneOut[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftClk <= 1'b0;
      latchEn  <= 1'b0;
      strobe   <= 1'b1;
      sustain  <= 1'b0;
    end else begin
      shiftClk <= ctl.clkHigh;
      latchEn  <= ctl.leHigh;
      strobe   <= ~ctl.dispOn;
      sustain  <= ctl.dispOn;
    end
  end

endmodule

// File: rtl/panel_load_seq.sv
`timescale 1ns/1ps
module panel_load_seq
  import panel_seq_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int DISP_W        = 16,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int SCK_HALF_NS   = 100,
  parameter int DATA_HOLD_NS  = 50,
  parameter int LE_GAP_NS     = 50,
  parameter int LE_WIDTH_NS   = 90,
  parameter int PULSE_MIN_NS  = 2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  output logic              wordReady,
  input  logic [WORD_W-1:0] wordData,
  input  logic [DISP_W-1:0] dispLen,
  output logic              sdOdd,
  output logic              sdEven,
  output logic              shiftClk,
  output logic              latchEn,
  output logic              strobe,
  output logic              sustain
);

  localparam int STEPS  = WORD_W / 2;
  localparam int BIT_W  = $clog2(STEPS);
  localparam int HALF_C = cycFromNs(SCK_HALF_NS, CLK_PERIOD_PS);
  localparam int HOLD_C = cycFromNs(DATA_HOLD_NS, CLK_PERIOD_PS);
  localparam int GAP_C  = cycFromNs(LE_GAP_NS, CLK_PERIOD_PS);
  localparam int LEW_C  = cycFromNs(LE_WIDTH_NS, CLK_PERIOD_PS);
  localparam int PMIN_C = cycFromNs(PULSE_MIN_NS, CLK_PERIOD_PS);
  localparam int PMIN_W = $clog2(PMIN_C + 1);
  localparam int CNT_W  = (DISP_W > PMIN_W) ? DISP_W : PMIN_W;

  seqCtl_t ctl;

  panel_seq_ctrl #(
    .STEPS(STEPS), .HALF(HALF_C), .HOLD(HOLD_C), .GAP(GAP_C), .LEW(LEW_C),
    .PMIN(PMIN_C), .DISP_W(DISP_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordReady(wordReady),
    .dispLen(dispLen), .ctl(ctl)
  );

  panel_seq_data #(.WORD_W(WORD_W), .STEPS(STEPS)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordData(wordData),
    .sdOdd(sdOdd), .sdEven(sdEven), .shiftClk(shiftClk), .latchEn(latchEn),
    .strobe(strobe), .sustain(sustain)
  );

endmodule

// File: rtl/panel_seq_chk.sv
`timescale 1ns/1ps
module panel_seq_chk #(
  parameter int LEW  = 5,
  parameter int PMIN = 100
) (
  input logic clk,
  input logic rstN,
  input logic wordReady,
  input logic sdOdd,
  input logic sdEven,
  input logic shiftClk,
  input logic latchEn,
  input logic strobe,
  input logic sustain
);

  logic [31:0] leRun;
  logic [31:0] susRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leRun  <= '0;
      susRun <= '0;
    end else begin
      leRun  <= latchEn ? leRun + 1 : '0;
      susRun <= sustain ? susRun + 1 : '0;
    end
  end

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (!shiftClk && !latchEn && !sustain)); // R2
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    shiftClk |-> $stable({sdOdd, sdEven})); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClk) |=> $stable({sdOdd, sdEven})); // R5
  AST_LE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> !shiftClk); // R6
  AST_LE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchEn) |-> (leRun >= 32'(LEW))); // R7
  AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk || latchEn) |-> (!sustain && strobe)); // R8
  AST_SUS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sustain) |-> (susRun >= 32'(PMIN))); // R9

endmodule

bind panel_load_seq panel_seq_chk #(
  .LEW(LEW_C), .PMIN(PMIN_C)
) u_chk (
  .clk(clk), .rstN(rstN), .wordReady(wordReady), .sdOdd(sdOdd), .sdEven(sdEven),
  .shiftClk(shiftClk), .latchEn(latchEn), .strobe(strobe), .sustain(sustain)
);

// File: tb/panel_load_seq_tb.sv
`timescale 1ns/1ps
module panel_load_seq_tb;

  localparam int HALF = 5;
  localparam int HOLD = 3;
  localparam int GAP  = 3;
  localparam int LEW  = 5;
  localparam int PMIN = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [31:0] wordData = '0;
  logic [15:0] dispLen = '0;
  logic        sdOdd, sdEven, shiftClk, latchEn, strobe, sustain;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  panel_load_seq u_dut (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordReady(wordReady),
    .wordData(wordData), .dispLen(dispLen), .sdOdd(sdOdd), .sdEven(sdEven),
    .shiftClk(shiftClk), .latchEn(latchEn), .strobe(strobe), .sustain(sustain)
  );

  // pin monitor, sampled on the falling clock edge
  int fallCnt, hiRun, loRun, sinceFall, hiBad, loBad, setupBad, holdBad;
  int gapLen, leLen, susLen, stbLow, overlapBad, readyBad, tailLen, susAfterLe;
  bit tailOn;
  logic [15:0] capOdd, capEven;
  logic pClk = 1'b0, pLe = 1'b0, pSus = 1'b0;
  logic [1:0] pD = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (wordValid && wordReady) begin
        fallCnt = 0; hiRun = 0; loRun = 0; sinceFall = 0; hiBad = 0; loBad = 0;
        setupBad = 0; holdBad = 0; gapLen = -1; leLen = 0; susLen = 0; stbLow = 0;
        overlapBad = 0; readyBad = 0; tailLen = 0; susAfterLe = 0; tailOn = 0;
        capOdd = '0; capEven = '0;
      end else begin
        if (shiftClk && !pClk) begin
          hiRun = 1;
          if (fallCnt > 0 && loRun != HALF) loBad++;
        end else if (shiftClk) begin
          hiRun++;
        end else if (pClk) begin
          if (hiRun != HALF) hiBad++;
          if (fallCnt < 16) begin
            capOdd[fallCnt]  = pD[1];
            capEven[fallCnt] = pD[0];
          end
          fallCnt++;
          sinceFall = 0;
          loRun = 1;
        end else begin
          loRun++;
          sinceFall++;
        end
        if ({sdOdd, sdEven} != pD) begin
          if (shiftClk || pClk) setupBad++;
          if (fallCnt > 0 && sinceFall < HOLD) holdBad++;
        end
        if (latchEn && !pLe) gapLen = sinceFall;
        if (latchEn) leLen++;
        if (sustain && !pSus && pLe && !latchEn) susAfterLe = 1;
        if (sustain) susLen++;
        if (!strobe) stbLow++;
        if ((sustain || !strobe) && (shiftClk || latchEn)) overlapBad++;
        if (wordReady && (shiftClk || latchEn || sustain)) readyBad++;
        if (!sustain && pSus) tailOn = 1;
        if (wordReady) tailOn = 0;
        if (tailOn && !wordReady) tailLen++;
      end
    end
    pClk = shiftClk; pLe = latchEn; pSus = sustain; pD = {sdOdd, sdEven};
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitReady();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (wordReady) return;
    end
    chk("R10", "wordReady never returned", 0, 1);
  endtask

  task automatic waitSustain(input logic level);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (sustain == level) return;
    end
    chk("R9", "sustain level not reached", int'(sustain), int'(level));
  endtask

  function automatic logic [15:0] expLane(input logic [31:0] w, input int ln);
    logic [15:0] v;
    for (int k = 0; k < 16; k++) v[k] = w[31 - 2*k - (1 - ln)];
    return v;
  endfunction

  task automatic offer(input logic [31:0] w, input logic [15:0] d);
    @(negedge clk); #2;
    wordData = w; dispLen = d; wordValid = 1'b1;
    waitReady();
    @(posedge clk); #2;
    wordValid = 1'b0;
  endtask

  task automatic checkRun(input logic [31:0] w, input int disp);
    int expSus;
    expSus = (disp > PMIN) ? disp : PMIN;
    chk("R3", "falling shift edges", fallCnt, 16);
    chk("R3", "odd-line bits", int'(capOdd), int'(expLane(w, 0)));
    chk("R3", "even-line bits", int'(capEven), int'(expLane(w, 1)));
    chk("R4", "bad high phases", hiBad, 0);
    chk("R4", "bad low phases", loBad, 0);
    chk("R5", "data changes while clock high", setupBad, 0);
    chk("R5", "data changes inside hold", holdBad, 0);
    chk("R6", "fall to latch gap", gapLen, GAP);
    chk("R7", "latch enable width", leLen, LEW);
    chk("R8", "sustain or strobe active during load", overlapBad, 0);
    chk("R8", "sustain rise right after latch", susAfterLe, 1);
    chk("R9", "sustain width", susLen, expSus);
    chk("R9", "strobe low width", stbLow, expSus);
    chk("R10", "blank tail before ready", tailLen, PMIN - 1);
    chk("R2", "ready while busy", readyBad, 0);
  endtask

  task automatic testReset();
    @(negedge clk); #1;
    chk("R1", "wordReady", int'(wordReady), 1);
    chk("R1", "shiftClk", int'(shiftClk), 0);
    chk("R1", "latchEn", int'(latchEn), 0);
    chk("R1", "sustain", int'(sustain), 0);
    chk("R1", "strobe", int'(strobe), 1);
  endtask

  task automatic testWord(input logic [31:0] w, input int disp);
    offer(w, 16'(disp));
    waitReady();
    checkRun(w, disp);
  endtask

  // R11: a word offered during display waits, and leaves the lines untouched
  task automatic testBusyOffer(input logic [31:0] a, input logic [31:0] b);
    offer(a, 16'd150);
    waitSustain(1'b1);
    @(negedge clk); #2;
    wordData = b; dispLen = 16'd120; wordValid = 1'b1;
    @(negedge clk); #1;
    chk("R11", "ready during display", int'(wordReady), 0);
    waitSustain(1'b0);
    chk("R11", "first word odd bits kept", int'(capOdd), int'(expLane(a, 0)));
    chk("R11", "first word even bits kept", int'(capEven), int'(expLane(a, 1)));
    chk("R11", "first word sustain width", susLen, 150);
    waitReady();
    @(posedge clk); #2;
    wordValid = 1'b0;
    waitReady();
    checkRun(b, 120);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    testReset();
    testWord(32'hA5C3_0F96, 150);
    testWord(32'h0000_0001, 20);
    testWord(32'h8000_0000, 100);
    testWord(32'hFFFF_0000, 101);
    testBusyOffer(32'h1234_5678, 32'hDEAD_BEEF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule